// File: doc/BRIEF.md
# SDRAM Mode Register Programming Sequencer

This block sits on the controller side of a DDR SDRAM interface. When asked, it writes the device's base mode register. A single-cycle trigger comes with the requested burst length code, burst type, CAS latency code and DLL-reset flag. The block first checks the request against the set of legal codes. A legal request is captured on the trigger cycle. The block then drives a precharge-all command and waits out the row-precharge time. It then drives the mode-register-set command with the mode fields on the address bus. It holds NOP until the mode-register delay has elapsed, and then pulses `done`.

An illegal request produces a one-cycle `err` pulse and no command activity. `busy` covers the whole legal sequence. Triggers that arrive while the block is busy are discarded. The precharge-to-MRS distance (`T_RP`) and the MRS-to-next-command distance (`T_MRD`) are parameters counted in clock cycles.

All command and address outputs are registered. The command lines are active-low. A NOP is `cs_n`=0 with `ras_n`, `cas_n` and `we_n` all 1.

Top module: `sdram_mode_prog`

## Requirements
- R1: During and after synchronous reset, the command lines show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), the address and bank outputs are zero, and busy, done and err are low.
- R2: When a legal trigger is sampled on a clock edge, the next cycle shows precharge-all (0,0,1,0) with address bit 10 set and every other address bit zero, and busy is high in that cycle.
- R3: The MRS command (0,0,0,0) appears exactly T_RP cycles after the precharge-all cycle, and only NOPs are driven between the two.
- R4: In the MRS cycle the address carries the burst length code on bits 2..0, the burst type on bit 3 (0 sequential, 1 interleave), the CAS latency code on bits 6..4 and the DLL-reset flag on bit 8. Bit 7, every bit above 8 and the whole bank address are 0.
- R5: A request is legal only when two conditions both hold. The burst length code must be 001, 010 or 011, or 111 with the burst type at 0. The latency code must be 011, 100 or 101.
- R6: An illegal trigger gives err high for exactly the one cycle after the trigger edge. No command other than NOP is driven, and busy stays low.
- R7: After the MRS cycle, NOPs are driven for T_MRD-1 cycles. In the cycle T_MRD after MRS, done is high for one cycle, busy is low and the lines show NOP.
- R8: A trigger that arrives while busy is high is ignored. The running sequence keeps its timing and no second sequence follows.
- R9: The request fields are captured on the trigger edge. Input changes after the trigger do not alter the address driven with MRS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Trigger, one cycle |
| bl_code | input | 3 | Requested burst length code |
| burst_il | input | 1 | Burst type, 1 = interleave |
| cl_code | input | 3 | Requested CAS latency code |
| dll_reset | input | 1 | Requested DLL-reset flag |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | BANK_W | Bank address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-request pulse |

## Verification
The assertions take three things for granted. The device is already idle and its clock enable is high. `T_RP` and `T_MRD` are at least 1. `start` is a clean synchronous level that reset has left low. The stimulus applies reset first and drives every input half a cycle away from the sampling edge. It sweeps all 256 combinations of the four request fields, so both the legal and the reserved codes reach the checker. During each legal run, the fields are inverted and a stray trigger is raised, and the timing properties must still hold.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdram_cmd_t;

    localparam sdram_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdram_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdram_cmd_t CMD_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TRP  = 2'd1,
        ST_TMRD = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [2:0] bl;
        logic       bt;
        logic [2:0] cl;
        logic       dll;
    } mode_req_t;

    localparam int MODE_BITS   = 9;
    localparam int ALL_BANK_BIT = 10;

    function automatic logic bl_ok(input mode_req_t r);
        return (r.bl == 3'd1) || (r.bl == 3'd2) || (r.bl == 3'd3) ||
               ((r.bl == 3'd7) && !r.bt);
    endfunction

    function automatic logic cl_ok(input mode_req_t r);
        return (r.cl == 3'd3) || (r.cl == 3'd4) || (r.cl == 3'd5);
    endfunction

    function automatic logic [MODE_BITS-1:0] mode_word(input mode_req_t r);
        return {r.dll, 1'b0, r.cl, r.bt, r.bl};
    endfunction

endpackage

// File: rtl/mrs_req_check.sv
module mrs_req_check
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  mode_req_t         req,
    output logic              legal,
    output logic [ADDR_W-1:0] mrs_addr
);
    localparam int PAD_W = ADDR_W - MODE_BITS;

    always_comb begin
        legal = bl_ok(req) && cl_ok(req);
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign mrs_addr = {{PAD_W{1'b0}}, mode_word(req)};
        end else begin : g_nopad
            assign mrs_addr = mode_word(req);
        end
    endgenerate

endmodule

// File: rtl/mrs_timer.sv
module mrs_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |-> (cnt != '0)); // R3

endmodule

// File: rtl/sdram_mode_prog.sv
module sdram_mode_prog
    import mrs_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int BANK_W = 2,
    parameter int T_RP   = 3,
    parameter int T_MRD  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        bl_code,
    input  logic              burst_il,
    input  logic [2:0]        cl_code,
    input  logic              dll_reset,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int CNT_MAX = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] TRP_LD  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] TMRD_LD = CNT_W'(T_MRD - 1);
    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << ALL_BANK_BIT;

    seq_state_t        state;
    mode_req_t         req_in;
    mode_req_t         held;
    mode_req_t         chk_req;
    sdram_cmd_t        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] mrs_addr;
    logic              legal;
    logic              accept;
    logic              t_load;
    logic [CNT_W-1:0]  t_val;
    logic              t_tick;
    logic              t_zero;

    assign req_in  = '{bl: bl_code, bt: burst_il, cl: cl_code, dll: dll_reset};
    assign chk_req = (state == ST_IDLE) ? req_in : held;

    mrs_req_check #(.ADDR_W(ADDR_W)) u_chk (
        .req      (chk_req),
        .legal    (legal),
        .mrs_addr (mrs_addr)
    );

    assign accept = (state == ST_IDLE) && start && legal;

    always_comb begin
        t_load = 1'b0;
        t_val  = TRP_LD;
        if (accept) begin
            t_load = 1'b1;
            t_val  = TRP_LD;
        end else if ((state == ST_TRP) && t_zero) begin
            t_load = 1'b1;
            t_val  = TMRD_LD;
        end
        t_tick = (state != ST_IDLE) && !t_zero && !t_load;
    end

    mrs_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .tick     (t_tick),
        .zero     (t_zero)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            held   <= '0;
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (legal) begin
                            held   <= req_in;
                            cmd_q  <= CMD_PRE;
                            addr_q <= PRE_ADDR;
                            busy   <= 1'b1;
                            state  <= ST_TRP;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_TRP: begin
                    if (t_zero) begin
                        cmd_q  <= CMD_MRS;
                        addr_q <= mrs_addr;
                        state  <= ST_TMRD;
                    end
                end
                ST_TMRD: begin
                    if (t_zero) begin
                        busy  <= 1'b0;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cs_n  = cmd_q.cs_n;
    assign ras_n = cmd_q.ras_n;
    assign cas_n = cmd_q.cas_n;
    assign we_n  = cmd_q.we_n;
    assign addr  = addr_q;
    assign ba    = '0;

    // Distance counter from the last precharge-all, saturating past T_RP.
    localparam int GAP_W = $clog2(T_RP + 2) + 1;
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= '0;
        end else if (cmd_q == CMD_PRE) begin
            gap <= GAP_W'(1);
        end else if ((gap != '0) && (gap != GAP_W'(T_RP + 1))) begin
            gap <= gap + 1'b1;
        end
    end

    AST_MRS_AFTER_TRP: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_MRS) |-> (gap == GAP_W'(T_RP))); // R3
    AST_CMD_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != CMD_NOP) |-> busy); // R2
    AST_MRS_FIELDS: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_MRS) |-> (addr[7] == 1'b0 && ba == '0 &&
                                (addr >> MODE_BITS) == '0)); // R4
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && cmd_q == CMD_NOP)); // R6
    AST_MRD_GAP: assert property (@(posedge clk) disable iff (rst)
        (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(held)); // R9

endmodule

// File: tb/sim_sdram_mode_prog.sv
module sim_sdram_mode_prog;
    localparam int ADDR_W = 11;
    localparam int BANK_W = 2;
    localparam int T_RP   = 3;
    localparam int T_MRD  = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [2:0]        bl_code = '0;
    logic              burst_il = 1'b0;
    logic [2:0]        cl_code = '0;
    logic              dll_reset = 1'b0;
    logic              cs_n, ras_n, cas_n, we_n;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] ba;
    logic              busy, done, err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sdram_mode_prog #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .T_RP(T_RP), .T_MRD(T_MRD)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .bl_code(bl_code),
        .burst_il(burst_il), .cl_code(cl_code), .dll_reset(dll_reset),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cmdv();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    // command codes {cs_n,ras_n,cas_n,we_n}: NOP 0111, PRE 0010, MRS 0000
    localparam int NOP = 4'b0111;
    localparam int PRE = 4'b0010;
    localparam int MRS = 4'b0000;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cmdv() == NOP, "R1 cmd", cmdv(), NOP);
        chk(addr == '0 && ba == '0, "R1 addr/ba", {ba, addr}, 0);
        chk({busy, done, err} == 3'b000, "R1 flags", {busy, done, err}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmdv() == NOP && !busy, "R1 after release", {busy, cmdv()}, NOP);

        for (int i = 0; i < 256; i++) begin
            logic [2:0] bl;
            logic       bt;
            logic [2:0] cl;
            logic       dl;
            bit         legal;
            int         exp_addr;
            bl = i[2:0];
            bt = i[3];
            cl = i[6:4];
            dl = i[7];
            legal = ((bl >= 3'd1 && bl <= 3'd3) || (bl == 3'd7 && !bt)) &&
                    (cl >= 3'd3 && cl <= 3'd5);
            exp_addr = (int'(dl) << 8) + (int'(cl) << 4) + (int'(bt) << 3) + int'(bl);

            bl_code = bl; burst_il = bt; cl_code = cl; dll_reset = dl;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(err == !legal, "R5 legality", err, !legal);

            if (!legal) begin
                chk(cmdv() == NOP && !busy, "R6 no command", {busy, cmdv()}, NOP);
                @(negedge clk);
                chk(!err && cmdv() == NOP && !busy, "R6 one-cycle err", {err, busy, cmdv()}, NOP);
                continue;
            end

            chk(cmdv() == PRE, "R2 precharge", cmdv(), PRE);
            chk(addr == 11'h400 && ba == '0, "R2 all-bank addr", addr, 11'h400);
            chk(busy && !done, "R2 busy", {busy, done}, 2);

            // R9: change request fields, R8: stray trigger while busy
            bl_code = ~bl; burst_il = ~bt; cl_code = ~cl; dll_reset = ~dl;
            start = 1'b1;
            for (int j = 1; j < T_RP; j++) begin
                @(negedge clk);
                start = 1'b0;
                chk(cmdv() == NOP && busy, "R3 R8 nop before MRS", {busy, cmdv()}, 8 + NOP);
            end
            @(negedge clk);
            start = 1'b0;
            chk(cmdv() == MRS && busy, "R3 MRS timing", {busy, cmdv()}, 8 + MRS);
            chk(int'(addr) == exp_addr, "R4 R9 MRS addr", addr, exp_addr);
            chk(ba == '0, "R4 bank", ba, 0);

            for (int j = 1; j < T_MRD; j++) begin
                @(negedge clk);
                chk(cmdv() == NOP && busy && !done, "R7 nop after MRS", {busy, done, cmdv()}, 16 + NOP);
            end
            @(negedge clk);
            chk(done && !busy && cmdv() == NOP, "R7 done", {busy, done, cmdv()}, 8 + NOP);
            @(negedge clk);
            chk(!done && !busy && cmdv() == NOP, "R7 R8 back idle", {busy, done, cmdv()}, NOP);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule